// File: doc/BRIEF.md
# Aligned Dual-Ratio Clock Divider

This block turns one input clock into two slower clocks that keep a fixed phase relation. The fast output runs at half the input rate. The slow output runs at a quarter or a sixth of the input rate, and a select input chooses between the two. A single counter drives both outputs, so every rising edge of the slow output lands on the same input edge as a rising edge of the fast output.

A run control starts and stops the counter. The run control is captured on the falling input edge, so it can only change while the input clock is low, and a stop or a start never cuts a clock pulse short. While the block is stopped, the outputs and the count keep their values. A marker output is high for one input cycle whenever both outputs rise together. An asynchronous master reset puts every copy of the block into the same phase. Several copies that leave reset together therefore stay in step.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While running, `half_clk` changes level on every rising edge of `clk_in`.
- R2: With `sel_six` = 0, `slow_clk` repeats 2 cycles high and then 2 cycles low. With `sel_six` = 1, it repeats 3 cycles high and then 3 cycles low.
- R3: Every rising edge of `slow_clk` occurs on the same `clk_in` edge as a rising edge of `half_clk`.
- R4: `sync_mark` goes high for exactly one input cycle, on the edge where `half_clk` and `slow_clk` both rise. At all other times it is low.
- R5: `run_en` is captured on the falling edge of `clk_in` and takes effect at the next rising edge. A pulse that starts after a rising edge and ends before the next falling edge has no effect.
- R6: While the captured run level is low, `half_clk`, `slow_clk`, `sync_mark` and the count all hold. Counting continues from the held state once the block runs again.
- R7: `mrst` = 1 clears the outputs at once, without waiting for a clock edge. After release, the first enabled rising edge raises `half_clk`, `slow_clk` and `sync_mark` together.
- R8: A change of `sel_six` is applied only where a slow period ends. The period already under way finishes at its old ratio.
- R9: If `run_en` and `sel_six` are held low after reset, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| run_en | input | 1 | Run control, captured on the falling edge |
| sel_six | input | 1 | Ratio select for the slow output: 0 gives divide by 4, 1 gives divide by 6 |
| half_clk | output | 1 | Input clock divided by 2 |
| slow_clk | output | 1 | Input clock divided by 4 or by 6 |
| sync_mark | output | 1 | One-cycle pulse when both outputs rise together |

## Verification
The assertions assume that `mrst` is applied at power-up, before the first checked edge, and that `run_en` is steady around each falling edge. The stimulus drives `run_en` and `sel_six` just after a rising edge. It also raises and lowers `mrst` between edges, so the captured run level and the ratio are always clean when the block samples them. The one deliberate narrow `run_en` pulse starts and ends inside the high half of the clock, well away from the capturing edge. It tests that such a pulse is ignored.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;

   typedef struct packed {
      logic half;
      logic slow;
      logic mark;
   } div_out_t;

   function automatic int ratio_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit ratio_ok(input int r);
      return (r >= 4) && ((r % 2) == 0);
   endfunction

endpackage

// File: rtl/div_run_sampler.sv
module div_run_sampler (
   input  logic clk_in,
   input  logic mrst,
   input  logic run_en,
   output logic run_q
);

   // Captured while the input clock is low, so no runt pulse reaches the counter
   always_ff @(negedge clk_in or posedge mrst) begin
      if (mrst) run_q <= 1'b0;
      else      run_q <= run_en;
   end

endmodule

// File: rtl/div_period_counter.sv
module div_period_counter #(
   parameter int RATIO_LO = 4,
   parameter int RATIO_HI = 6,
   parameter int CNT_W    = 3
) (
   input  logic             clk_in,
   input  logic             mrst,
   input  logic             run_q,
   input  logic             sel_six,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             slow_nxt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] LO_END  = CNT_W'(RATIO_LO - 1);
   localparam logic [CNT_W-1:0] HI_END  = CNT_W'(RATIO_HI - 1);
   localparam logic [CNT_W-1:0] LO_HALF = CNT_W'(RATIO_LO / 2);
   localparam logic [CNT_W-1:0] HI_HALF = CNT_W'(RATIO_HI / 2);

   logic [CNT_W-1:0] cnt_q;
   logic             six_act;
   logic             six_nxt;
   logic [CNT_W-1:0] per_end;

   always_comb begin
      per_end  = six_act ? HI_END : LO_END;
      wrap     = (cnt_q >= per_end);
      six_nxt  = wrap ? sel_six : six_act;
      cnt_nxt  = wrap ? '0 : cnt_q + 1'b1;
      slow_nxt = six_nxt ? (cnt_nxt < HI_HALF) : (cnt_nxt < LO_HALF);
   end

   // Reset parks the count on the last state, so the first edge opens a period
   always_ff @(posedge clk_in or posedge mrst) begin
      if (mrst) begin
         cnt_q   <= LO_END;
         six_act <= 1'b0;
      end else if (run_q) begin
         cnt_q   <= cnt_nxt;
         six_act <= six_nxt;
      end
   end

   assert_select_steady_R8: assert property (@(posedge clk_in) disable iff (mrst)
      (run_q && !wrap) |=> $stable(six_act));

   assert_count_frozen_R6: assert property (@(posedge clk_in) disable iff (mrst)
      !run_q |=> $stable(cnt_q));

endmodule

// File: rtl/div_out_stage.sv
module div_out_stage
   import dual_div_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             clk_in,
   input  logic             mrst,
   input  logic             run_q,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             slow_nxt,
   input  logic             wrap,
   output div_out_t         outs
);

   always_ff @(posedge clk_in or posedge mrst) begin
      if (mrst) begin
         outs <= '0;
      end else if (run_q) begin
         outs.half <= ~cnt_nxt[0];
         outs.slow <= slow_nxt;
         outs.mark <= wrap;
      end
   end

   assert_half_toggles_R1: assert property (@(posedge clk_in) disable iff (mrst)
      run_q |=> (outs.half != $past(outs.half)));

   assert_slow_rise_aligned_R3: assert property (@(posedge clk_in) disable iff (mrst)
      $rose(outs.slow) |-> $rose(outs.half));

   assert_mark_needs_both_R4: assert property (@(posedge clk_in) disable iff (mrst)
      outs.mark |-> (outs.half && outs.slow));

   assert_mark_single_R4: assert property (@(posedge clk_in) disable iff (mrst)
      (outs.mark && run_q) |=> !outs.mark);

   assert_hold_when_stopped_R6: assert property (@(posedge clk_in) disable iff (mrst)
      !run_q |=> ($stable(outs.half) && $stable(outs.slow) && $stable(outs.mark)));

   assert_reset_clear_R7: assert property (@(posedge clk_in)
      mrst |-> (outs == '0));

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
   import dual_div_pkg::*;
#(
   parameter int RATIO_LO = 4,
   parameter int RATIO_HI = 6
) (
   input  logic clk_in,
   input  logic mrst,
   input  logic run_en,
   input  logic sel_six,
   output logic half_clk,
   output logic slow_clk,
   output logic sync_mark
);

   localparam int RATIO_TOP = ratio_max(RATIO_LO, RATIO_HI);
   localparam int CNT_W     = $clog2(RATIO_TOP);

   generate
      if (!ratio_ok(RATIO_LO)) begin : g_bad_lo
         $error("RATIO_LO must be even and at least 4");
      end
      if (!ratio_ok(RATIO_HI)) begin : g_bad_hi
         $error("RATIO_HI must be even and at least 4");
      end
   endgenerate

   logic             run_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             slow_nxt;
   logic             wrap;
   div_out_t         outs;

   div_run_sampler u_run (
      .clk_in (clk_in),
      .mrst   (mrst),
      .run_en (run_en),
      .run_q  (run_q)
   );

   div_period_counter #(
      .RATIO_LO (RATIO_LO),
      .RATIO_HI (RATIO_HI),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk_in   (clk_in),
      .mrst     (mrst),
      .run_q    (run_q),
      .sel_six  (sel_six),
      .cnt_nxt  (cnt_nxt),
      .slow_nxt (slow_nxt),
      .wrap     (wrap)
   );

   div_out_stage #(
      .CNT_W (CNT_W)
   ) u_out (
      .clk_in   (clk_in),
      .mrst     (mrst),
      .run_q    (run_q),
      .cnt_nxt  (cnt_nxt),
      .slow_nxt (slow_nxt),
      .wrap     (wrap),
      .outs     (outs)
   );

   assign half_clk  = outs.half;
   assign slow_clk  = outs.slow;
   assign sync_mark = outs.mark;

   assert_idle_low_R9: assert property (@(posedge clk_in) disable iff (mrst)
      (!run_q && !$past(run_q) && !$past(half_clk)) |-> !half_clk);

endmodule

// File: tb/tb_dual_ratio_clkdiv.sv
module tb_dual_ratio_clkdiv;

   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic mrst = 1'b1;
   logic run_en = 1'b0;
   logic sel_six = 1'b0;
   logic half_clk, slow_clk, sync_mark;

   int total = 0;
   int fails = 0;

   typedef struct {
      logic [2:0] val;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t cur;

   int   m_cnt;
   bit   m_six;
   logic m_h, m_s, m_p;

   always #(CLK_P/2) clk = ~clk;

   dual_ratio_clkdiv dut (
      .clk_in    (clk),
      .mrst      (mrst),
      .run_en    (run_en),
      .sel_six   (sel_six),
      .half_clk  (half_clk),
      .slow_clk  (slow_clk),
      .sync_mark (sync_mark)
   );

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {half,slow,mark} actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = 3; m_six = 0; m_h = 0; m_s = 0; m_p = 0;
   endtask

   // Next expected state, taken from the ratio, duty and marker rules
   task automatic model_step(input bit e, input bit s);
      if (e) begin
         if (m_cnt >= (m_six ? 5 : 3)) begin
            m_cnt = 0;
            m_six = s;
         end else begin
            m_cnt++;
         end
         m_h = (m_cnt % 2) == 0;
         m_s = m_cnt < (m_six ? 3 : 2);
         m_p = (m_cnt == 0);
      end
   endtask

   // Entered at posedge+1; the edge that follows is the one this cycle predicts
   task automatic cycle(input bit e, input bit s, input string tag);
      exp_t it;
      run_en  = e;
      sel_six = s;
      @(posedge clk);
      model_step(e, s);
      it.val = {m_h, m_s, m_p};
      it.tag = tag;
      exp_q.push_back(it);
      #1;
   endtask

   // A run pulse that starts and ends inside the high half of the clock
   task automatic narrow_pulse(input string tag);
      exp_t it;
      run_en = 1'b1;
      #2;
      run_en = 1'b0;
      @(posedge clk);
      model_step(1'b0, sel_six);
      it.val = {m_h, m_s, m_p};
      it.tag = tag;
      exp_q.push_back(it);
      #1;
   endtask

   always @(posedge clk) begin
      #3;
      if (exp_q.size() > 0) begin
         cur = exp_q.pop_front();
         chk(cur.tag, {half_clk, slow_clk, sync_mark}, cur.val);
      end
   end

   initial begin
      #(CLK_P * 100000);
      fails++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      model_reset();
      repeat (2) @(posedge clk);
      #1;
      chk("R7 in reset", {half_clk, slow_clk, sync_mark}, 3'b000);
      mrst = 1'b0;
      for (int i = 0; i < 4; i++) cycle(0, 0, "R9 idle");
      cycle(1, 0, "R7 first edge");
      for (int i = 0; i < 11; i++) cycle(1, 0, "R2 div4 R1 R3 R4");
      cycle(1, 0, "R8 mid period");
      cycle(1, 1, "R8 old ratio");
      cycle(1, 1, "R8 old ratio");
      for (int i = 0; i < 12; i++) cycle(1, 1, "R2 div6 R3 R4");
      cycle(1, 1, "R6 before stop");
      cycle(1, 1, "R6 before stop");
      for (int i = 0; i < 4; i++) cycle(0, 1, "R6 held");
      for (int i = 0; i < 8; i++) cycle(1, 1, "R6 resume");
      for (int i = 0; i < 3; i++) narrow_pulse("R5 narrow pulse");
      cycle(1, 0, "R8 back to div4");
      for (int i = 0; i < 12; i++) cycle(1, 0, "R8 div4 again");
      run_en = 1'b0;
      @(posedge clk);
      #4;
      exp_q.delete();
      mrst = 1'b1;
      #1;
      chk("R7 async clear", {half_clk, slow_clk, sync_mark}, 3'b000);
      @(posedge clk);
      #1;
      mrst = 1'b0;
      model_reset();
      cycle(0, 1, "R9 after reset");
      cycle(1, 1, "R7 first edge");
      for (int i = 0; i < 7; i++) cycle(1, 1, "R2 div6 after reset");
      @(posedge clk);
      #5;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule